// File: doc/BRIEF.md
# Acquisition Trigger Sequencer

This block decides which camera frames, or in linescan work which lines, reach the capture datapath. One of several external trigger lines is chosen and brought into the clock domain through a synchroniser. It is then treated as either a rising edge or a held level. A programmed capture policy turns the resulting trigger events into a per-cycle acquire qualifier that the pixel datapath ANDs with its data. Only whole frames or whole lines are ever qualified.

Four policies are offered. Free-running capture ignores the trigger. One-shot capture starts at the first trigger and runs until the block is disarmed. Per-frame capture takes one frame per trigger. Envelope capture is meant for line cameras and takes every line that starts while the trigger is held. A trigger can be held back by a non-retriggerable delay that counts either microsecond ticks or line starts. Status pulses report accepted triggers, discarded triggers and completed captures.

Top module: `acq_trig_seq`

## Requirements
- R1: While rst_n is low and in the cycle after it rises, acq_en, acq_done, trig_seen and trig_drop are all 0.
- R2: cfg_src picks trigger line trig_in[cfg_src]; pulses on any other line produce no trig_seen pulse and no capture.
- R3: With cfg_edge = 0 (level sensing), every cycle in which the synchronised selected line is high is a trigger event, so a held line yields many trig_seen pulses and a capture of every frame that starts while it is held.
- R4: With cfg_mode = 0 (free run) and cfg_arm = 1, every frame is captured and trigger inputs produce no trig_seen pulse.
- R5: With cfg_mode = 1 (one-shot), no frame is captured until the first effective trigger; from then on every frame is captured until cfg_arm goes low.
- R6: With cfg_mode = 2 (per frame) and cfg_edge = 1 (rising-edge sensing), each effective trigger enables exactly one following frame; several triggers before one frame still enable one frame, and no trigger means no capture.
- R7: A frame is captured only when the effective trigger precedes the cycle in which fval is first seen high; acq_en is then high in exactly every fval-high cycle of that frame and in no cycle of any frame that was not captured.
- R8: acq_done is a one-cycle pulse in the cycle after the first low cycle that follows a captured frame (area modes), or a captured line (envelope mode); uncaptured frames or lines give none.
- R9: With cfg_dly_lines = 0 and cfg_dly_cnt = N > 0, the effective trigger (trig_seen) follows the N-th us_tick after the trigger event; with N = 0 it follows the event at once.
- R10: With cfg_dly_lines = 1, the delay counts rising edges of lval instead, and us_tick has no effect on it.
- R11: A trigger event arriving while a delay is pending is discarded, produces one trig_drop pulse, and neither restarts nor extends the running delay.
- R12: With cfg_mode = 3 (envelope), a line is captured whole when the synchronised selected line is high in the cycle where lval is first seen high; lines starting while it is low are not captured, a line already running when it rises is not captured, and the delay stage is bypassed (no trig_seen).
- R13: Lowering cfg_arm blocks new captures and forgets one-shot and per-frame state, so after re-arming a new trigger is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | N_TRIG | Asynchronous external trigger lines |
| fval | input | 1 | Camera frame-valid, synchronous to clk |
| lval | input | 1 | Camera line-valid, synchronous to clk |
| us_tick | input | 1 | One-cycle microsecond strobe |
| cfg_mode | input | 2 | Capture policy: 0 free run, 1 one-shot, 2 per frame, 3 envelope |
| cfg_arm | input | 1 | Enables capture; low clears policy state |
| cfg_src | input | SEL_W | Index of the trigger line in use |
| cfg_edge | input | 1 | 1 rising-edge sensing, 0 level sensing |
| cfg_dly_lines | input | 1 | Delay unit: 0 microsecond ticks, 1 line starts |
| cfg_dly_cnt | input | DLY_W | Delay length in units, 0 for none |
| acq_en | output | 1 | Acquire qualifier for the datapath |
| acq_done | output | 1 | Pulse after each captured frame or line |
| trig_seen | output | 1 | Pulse when a trigger takes effect |
| trig_drop | output | 1 | Pulse when a trigger is discarded during a delay |

## Verification
The bench drives a trigger on the same edge that raises fval. A design that compares against the raw input, or lets the trigger act on a frame already started, would qualify part of that frame instead of waiting for the next one. It counts how many acquire cycles each frame yields, so a design that loses the first fval cycle or leaks into the blanking would be off by one. It fires a second trigger during a pending delay and then keeps ticking. A retriggerable design would restart the count or give two effective triggers. It also checks that line-counted delays ignore microsecond ticks, and that a stale per-frame or one-shot state does not survive disarming.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

   typedef enum logic [1:0] {
      MODE_FREE     = 2'd0,
      MODE_ONESHOT  = 2'd1,
      MODE_PERFRAME = 2'd2,
      MODE_ENVELOPE = 2'd3
   } cap_mode_e;

   typedef enum logic {
      UNIT_TIME  = 1'b0,
      UNIT_LINES = 1'b1
   } dly_unit_e;

endpackage

// File: rtl/trig_front.sv
module trig_front #(
   parameter int N_TRIG      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_TRIG-1:0] trig_in,
   input  logic [SEL_W-1:0]  src_sel,
   input  logic              edge_mode,
   output logic              sel_lvl,
   output logic              evt
);

   logic [N_TRIG-1:0][SYNC_STAGES-1:0] chain_q;
   logic [N_TRIG-1:0]                  synced;
   logic                               pick;
   logic                               pick_q;

   // one synchroniser chain per trigger line
   for (genvar gi = 0; gi < N_TRIG; gi++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) chain_q[gi] <= '0;
         else        chain_q[gi] <= {chain_q[gi][SYNC_STAGES-2:0], trig_in[gi]};
      end
      assign synced[gi] = chain_q[gi][SYNC_STAGES-1];
   end

   always_comb begin
      pick = 1'b0;
      for (int i = 0; i < N_TRIG; i++) begin
         if (src_sel == SEL_W'(i)) pick = synced[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pick_q <= 1'b0;
      else        pick_q <= pick;
   end

   assign sel_lvl = pick;
   assign evt     = edge_mode ? (pick & ~pick_q) : pick;

endmodule

// File: rtl/trig_delay.sv
module trig_delay
   import acq_trig_pkg::*;
#(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             evt_in,
   input  logic             us_tick,
   input  logic             lval,
   input  dly_unit_e        unit_sel,
   input  logic [DLY_W-1:0] dly_cnt,
   output logic             eff_trig,
   output logic             drop
);

   logic             busy_q;
   logic [DLY_W-1:0] rem_q;
   logic             lval_q;
   logic             unit_step;

   always_ff @(posedge clk) begin
      if (!rst_n) lval_q <= 1'b0;
      else        lval_q <= lval;
   end

   assign unit_step = (unit_sel == UNIT_LINES) ? (lval & ~lval_q) : us_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         rem_q    <= '0;
         eff_trig <= 1'b0;
         drop     <= 1'b0;
      end else begin
         eff_trig <= 1'b0;
         drop     <= 1'b0;
         if (!enable) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            // pending delay: new events are thrown away
            if (evt_in) drop <= 1'b1;
            if (unit_step) begin
               if (rem_q == DLY_W'(1)) begin
                  busy_q   <= 1'b0;
                  eff_trig <= 1'b1;
               end else begin
                  rem_q <= rem_q - DLY_W'(1);
               end
            end
         end else if (evt_in) begin
            if (dly_cnt == '0) begin
               eff_trig <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               rem_q  <= dly_cnt;
            end
         end
      end
   end

endmodule

// File: rtl/cap_policy.sv
module cap_policy
   import acq_trig_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  cap_mode_e mode,
   input  logic      arm,
   input  logic      eff_trig,
   input  logic      env_lvl,
   input  logic      fval,
   input  logic      lval,
   output logic      acq_en,
   output logic      acq_done
);

   logic unit_v;
   logic unit_q;
   logic unit_rise;
   logic unit_fall;
   logic run_q;
   logic pend_q;
   logic cap_q;
   logic go;
   logic start;

   // envelope mode works on lines, the others on frames
   assign unit_v    = (mode == MODE_ENVELOPE) ? lval : fval;
   assign unit_rise = unit_v & ~unit_q;
   assign unit_fall = ~unit_v & unit_q;

   always_comb begin
      unique case (mode)
         MODE_FREE:     go = 1'b1;
         MODE_ONESHOT:  go = run_q;
         MODE_PERFRAME: go = pend_q;
         MODE_ENVELOPE: go = env_lvl;
         default:       go = 1'b0;
      endcase
   end

   assign start  = unit_rise & go & arm;
   assign acq_en = unit_v & (cap_q | start);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unit_q   <= 1'b0;
         cap_q    <= 1'b0;
         acq_done <= 1'b0;
      end else begin
         unit_q   <= unit_v;
         acq_done <= unit_fall & cap_q;
         if (start)          cap_q <= 1'b1;
         else if (unit_fall) cap_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                             run_q <= 1'b0;
      else if (!arm || mode != MODE_ONESHOT)  run_q <= 1'b0;
      else if (eff_trig)                      run_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                             pend_q <= 1'b0;
      else if (!arm || mode != MODE_PERFRAME) pend_q <= 1'b0;
      else                                    pend_q <= (pend_q & ~unit_rise) | eff_trig;
   end

endmodule

// File: rtl/acq_trig_seq.sv
module acq_trig_seq
   import acq_trig_pkg::*;
#(
   parameter  int N_TRIG      = 4,
   parameter  int DLY_W       = 16,
   parameter  int SYNC_STAGES = 2,
   localparam int SEL_W       = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_TRIG-1:0] trig_in,
   input  logic              fval,
   input  logic              lval,
   input  logic              us_tick,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_arm,
   input  logic [SEL_W-1:0]  cfg_src,
   input  logic              cfg_edge,
   input  logic              cfg_dly_lines,
   input  logic [DLY_W-1:0]  cfg_dly_cnt,
   output logic              acq_en,
   output logic              acq_done,
   output logic              trig_seen,
   output logic              trig_drop
);

   if (N_TRIG < 1) begin : g_bad_ntrig
      $error("acq_trig_seq: N_TRIG must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("acq_trig_seq: SYNC_STAGES must be at least 2");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("acq_trig_seq: DLY_W must be at least 1");
   end

   cap_mode_e mode;
   dly_unit_e unit_sel;
   logic      sel_lvl;
   logic      evt;
   logic      trig_path_on;
   logic      eff_trig;

   assign mode         = cap_mode_e'(cfg_mode);
   assign unit_sel     = dly_unit_e'(cfg_dly_lines);
   assign trig_path_on = cfg_arm & ((mode == MODE_ONESHOT) | (mode == MODE_PERFRAME));

   trig_front #(
      .N_TRIG      (N_TRIG),
      .SYNC_STAGES (SYNC_STAGES),
      .SEL_W       (SEL_W)
   ) front_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_in   (trig_in),
      .src_sel   (cfg_src),
      .edge_mode (cfg_edge),
      .sel_lvl   (sel_lvl),
      .evt       (evt)
   );

   trig_delay #(
      .DLY_W (DLY_W)
   ) delay_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (trig_path_on),
      .evt_in   (evt),
      .us_tick  (us_tick),
      .lval     (lval),
      .unit_sel (unit_sel),
      .dly_cnt  (cfg_dly_cnt),
      .eff_trig (eff_trig),
      .drop     (trig_drop)
   );

   cap_policy policy_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .arm      (cfg_arm),
      .eff_trig (eff_trig),
      .env_lvl  (sel_lvl),
      .fval     (fval),
      .lval     (lval),
      .acq_en   (acq_en),
      .acq_done (acq_done)
   );

   assign trig_seen = eff_trig;

endmodule

// File: rtl/acq_trig_seq_chk.sv
module acq_trig_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fval,
   input logic       lval,
   input logic [1:0] cfg_mode,
   input logic       acq_en,
   input logic       acq_done,
   input logic       trig_seen
);

   // R7
   en_in_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acq_en |-> ((cfg_mode == 2'd3) ? lval : fval));

   // R8
   done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_done && $past(cfg_mode) != 2'd3 && $past(cfg_mode, 2) != 2'd3)
         |-> (!$past(fval) && $past(fval, 2)));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acq_done |=> !acq_done);

   // R4
   free_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_mode) == 2'd0) |-> !trig_seen);

   // R12
   env_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_mode) == 2'd3) |-> !trig_seen);

endmodule

bind acq_trig_seq acq_trig_seq_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .fval      (fval),
   .lval      (lval),
   .cfg_mode  (cfg_mode),
   .acq_en    (acq_en),
   .acq_done  (acq_done),
   .trig_seen (trig_seen)
);

// File: tb/acq_trig_seq_tb_top.sv
module acq_trig_seq_tb_top;

   localparam int CLK_PER = 10;
   localparam int NT      = 4;
   localparam int DW      = 8;
   localparam int LINES   = 3;
   localparam int WID     = 4;
   localparam int FH      = 1 + LINES * (WID + 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NT-1:0] trig_in = '0;
   logic          fval = 1'b0;
   logic          lval = 1'b0;
   logic          us_tick = 1'b0;
   logic [1:0]    cfg_mode = 2'd0;
   logic          cfg_arm = 1'b0;
   logic [1:0]    cfg_src = 2'd1;
   logic          cfg_edge = 1'b1;
   logic          cfg_dly_lines = 1'b0;
   logic [DW-1:0] cfg_dly_cnt = '0;
   logic          acq_en, acq_done, trig_seen, trig_drop;

   int n_chk = 0;
   int n_fail = 0;
   int en_cnt = 0, done_cnt = 0, seen_cnt = 0, drop_cnt = 0;
   int e0, d0, s0, p0;

   always #(CLK_PER/2) clk = ~clk;

   acq_trig_seq #(.N_TRIG(NT), .DLY_W(DW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .fval(fval), .lval(lval),
      .us_tick(us_tick), .cfg_mode(cfg_mode), .cfg_arm(cfg_arm), .cfg_src(cfg_src),
      .cfg_edge(cfg_edge), .cfg_dly_lines(cfg_dly_lines), .cfg_dly_cnt(cfg_dly_cnt),
      .acq_en(acq_en), .acq_done(acq_done), .trig_seen(trig_seen), .trig_drop(trig_drop)
   );

   // counts sampled a quarter period after each rising edge
   always @(posedge clk) begin
      #(CLK_PER/4);
      if (rst_n) begin
         if (acq_en)    en_cnt++;
         if (acq_done)  done_cnt++;
         if (trig_seen) seen_cnt++;
         if (trig_drop) drop_cnt++;
      end
   end

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic snap();
      e0 = en_cnt; d0 = done_cnt; s0 = seen_cnt; p0 = drop_cnt;
   endtask

   task automatic pulse_trig(input int idx);
      trig_in[idx] = 1'b1;
      step(3);
      trig_in[idx] = 1'b0;
      step(6);
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         us_tick = 1'b1; step(1);
         us_tick = 1'b0; step(1);
      end
   endtask

   task automatic line_out(input int n);
      repeat (n) begin
         lval = 1'b1; step(2);
         lval = 1'b0; step(2);
      end
   endtask

   // one frame; with mid=1 the trigger line rises together with fval
   task automatic frame(input bit mid);
      fval = 1'b1;
      if (mid) trig_in[1] = 1'b1;
      step(1);
      for (int l = 0; l < LINES; l++) begin
         lval = 1'b1; step(WID);
         lval = 1'b0; step(2);
         if (mid) trig_in[1] = 1'b0;
      end
      fval = 1'b0;
      step(6);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PER * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      step(4);
      // R1 reset state
      check("R1 acq_en in reset", int'(acq_en), 0);
      check("R1 acq_done in reset", int'(acq_done), 0);
      check("R1 trig_seen in reset", int'(trig_seen), 0);
      rst_n = 1'b1;
      step(1);
      check("R1 acq_en after reset", int'(acq_en), 0);
      check("R1 trig_drop after reset", int'(trig_drop), 0);

      // R4 free run
      cfg_arm = 1'b1; cfg_mode = 2'd0; step(3);
      snap(); frame(0); frame(0);
      check("R4 free-run acq cycles", en_cnt - e0, 2 * FH);
      check("R8 free-run done pulses", done_cnt - d0, 2);
      snap(); pulse_trig(1);
      check("R4 trigger ignored in free run", seen_cnt - s0, 0);

      // R6 / R2 per-frame and source selection
      cfg_mode = 2'd2; step(3);
      snap(); frame(0);
      check("R6 no trigger no frame", en_cnt - e0, 0);
      snap(); pulse_trig(0); frame(0);
      check("R2 unselected line no trig", seen_cnt - s0, 0);
      check("R2 unselected line no frame", en_cnt - e0, 0);
      snap(); pulse_trig(1);
      check("R9 zero delay immediate", seen_cnt - s0, 1);
      frame(0);
      check("R6 one frame per trigger", en_cnt - e0, FH);
      check("R8 done for captured frame", done_cnt - d0, 1);
      snap(); frame(0);
      check("R6 second frame not captured", en_cnt - e0, 0);
      check("R8 no done for skipped frame", done_cnt - d0, 0);
      snap(); pulse_trig(1); pulse_trig(1); frame(0); frame(0);
      check("R6 two triggers one frame", en_cnt - e0, FH);

      // R7 trigger coincident with frame start
      snap(); frame(1);
      check("R7 frame in progress not captured", en_cnt - e0, 0);
      snap(); frame(0);
      check("R7 next frame captured whole", en_cnt - e0, FH);

      // R3 level sensing
      cfg_edge = 1'b0; step(2);
      snap(); trig_in[1] = 1'b1; step(6); frame(0); frame(0);
      check("R3 held level many events", int'((seen_cnt - s0) > 1), 1);
      check("R3 held level captures each frame", en_cnt - e0, 2 * FH);
      trig_in[1] = 1'b0; step(6);
      snap(); frame(0);
      check("R3 pending from held level", en_cnt - e0, FH);
      snap(); frame(0);
      check("R3 released level no frame", en_cnt - e0, 0);
      // R2 edge sensing with a held line
      cfg_edge = 1'b1; step(2);
      snap(); trig_in[1] = 1'b1; step(6); frame(0); frame(0);
      check("R2 held line one edge", seen_cnt - s0, 1);
      check("R2 held line one frame", en_cnt - e0, FH);
      trig_in[1] = 1'b0; step(6);

      // R5 one-shot, R13 disarm
      cfg_mode = 2'd1; step(3);
      snap(); frame(0);
      check("R5 no capture before trigger", en_cnt - e0, 0);
      pulse_trig(1);
      snap(); frame(0); frame(0); frame(0);
      check("R5 all following frames", en_cnt - e0, 3 * FH);
      check("R8 one-shot done pulses", done_cnt - d0, 3);
      cfg_arm = 1'b0; step(2);
      snap(); frame(0);
      check("R13 disarmed no capture", en_cnt - e0, 0);
      cfg_arm = 1'b1; step(2);
      snap(); frame(0);
      check("R13 re-arm needs new trigger", en_cnt - e0, 0);

      // R9 time delay
      cfg_mode = 2'd2; cfg_dly_cnt = DW'(3); cfg_dly_lines = 1'b0; step(3);
      snap(); pulse_trig(1); tick(2); step(2);
      check("R9 not before N ticks", seen_cnt - s0, 0);
      tick(1); step(2);
      check("R9 after N ticks", seen_cnt - s0, 1);
      snap(); frame(0);
      check("R9 delayed trigger captures", en_cnt - e0, FH);

      // R11 non-retriggerable
      snap(); pulse_trig(1); pulse_trig(1);
      check("R11 drop pulse", drop_cnt - p0, 1);
      tick(3); step(2);
      check("R11 delay not restarted", seen_cnt - s0, 1);
      tick(3); step(2);
      check("R11 discarded trigger lost", seen_cnt - s0, 1);
      snap(); frame(0); frame(0);
      check("R11 only one frame", en_cnt - e0, FH);

      // R10 line delay
      cfg_dly_cnt = DW'(2); cfg_dly_lines = 1'b1; step(3);
      snap(); pulse_trig(1); tick(3); line_out(1); step(2);
      check("R10 ticks and one line not enough", seen_cnt - s0, 0);
      line_out(1); step(2);
      check("R10 fires after N lines", seen_cnt - s0, 1);
      snap(); frame(0);
      check("R10 frame captured", en_cnt - e0, FH);

      // R12 envelope
      cfg_mode = 2'd3; cfg_dly_cnt = '0; cfg_dly_lines = 1'b0; step(3);
      snap(); trig_in[1] = 1'b1; step(5); frame(0);
      check("R12 lines while held", en_cnt - e0, LINES * WID);
      check("R8 done per line", done_cnt - d0, LINES);
      check("R12 delay bypassed", seen_cnt - s0, 0);
      trig_in[1] = 1'b0; step(5);
      snap(); frame(0);
      check("R12 lines while low", en_cnt - e0, 0);
      snap();
      fval = 1'b1; step(1);
      lval = 1'b1; trig_in[1] = 1'b1; step(WID);
      lval = 1'b0; step(2);
      lval = 1'b1; step(WID);
      lval = 1'b0; step(2);
      fval = 1'b0; trig_in[1] = 1'b0; step(6);
      check("R12 running line skipped", en_cnt - e0, WID);
      check("R12 done count", done_cnt - d0, 1);

      summary();
   end

endmodule